// File: doc/BRIEF.md
# Programmable lookup-table logic gate

This block is a universal gate whose function comes from memory rather than from wired logic. A four-bit operation code and two operands, L and R, each `OPND_W` bits wide, are joined into one table address. The word stored at that address is the result. The table holds sixteen slots of `2^(2*OPND_W)` entries each. It covers modular add and subtract, the usual bitwise functions, both halves of a product, and a family of shifts and rotates selected by R.

The block fills its own table. After a synchronous reset, an internal sequencer steps through every address, one per clock. It takes over the memory address and write enable and stores the correct result for each entry. When the last entry is written, the memory switches to operating mode and `ready` rises. In operating mode the inputs drive the address, writes are off, and each lookup returns its result one clock later, like a synchronous RAM read. Any lookup issued before the table is complete returns zero. The default `OPND_W` is 4 and keeps the table at 4096 entries; the bench builds the six-bit configuration of 65536 entries.

Top module: `prog_lut_gate`

## Requirements
- R1: The table address is {op_sel, opnd_l, opnd_r}, with op_sel in the top four bits and R in the low `OPND_W` bits. A lookup presented before a clock edge at which `ready` is high shows its stored word on `result` after that edge.
- R2: Codes 0, 1 and 2 give L+R, L−R and R−L, each modulo 2^OPND_W.
- R3: Codes 3 to 9 give, in this order: NOT L, L AND R, L NAND R, L OR R, L NOR R, L XOR R, L AND NOT R.
- R4: Code 10 gives the low `OPND_W` bits of the full product L×R. Code 11 gives its high `OPND_W` bits.
- R5: Code 12 acts on L. R[OPND_W-1:OPND_W-2] selects the operation: 00 logical left shift, 01 logical right shift, 10 rotate left, 11 rotate right. R[A-1:0], with A = clog2(OPND_W), is the amount. For shifts, an amount of OPND_W or more gives zero. For rotates, the amount is taken modulo OPND_W.
- R6: Codes 13, 14 and 15 always return zero.
- R7: While reset is asserted, `ready` and `result` are low. After reset is released, the loader writes one entry per clock, and `ready` is first seen high exactly 2^(4+2·OPND_W) clocks later.
- R8: A lookup sampled at a clock edge where `ready` is low returns zero, whatever the inputs are.
- R9: Once high, `ready` stays high until the next reset.
- R10: A reset asserted in operating mode drops `ready` and restarts the full fill. The fill again takes exactly 2^(4+2·OPND_W) clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; starts a table fill |
| op_sel | input | 4 | Operation slot code |
| opnd_l | input | OPND_W | Left operand L |
| opnd_r | input | OPND_W | Right operand R |
| result | output | OPND_W | Looked-up word, one clock after the request |
| ready | output | 1 | Table complete, operating mode active |

## Verification
Some properties are checked on every clock. These are: the reset state, zero output for lookups while the fill is running, zero output for the three empty slots, `ready` never falling, the fill length counted against `ready` rising, and modular addition on live traffic. Only the bench scenarios can show that every other slot holds the right word. This covers product halves and the shift and rotate variants at amounts of six and seven. The bench also confirms that a reset in operating mode really reloads a table that then answers correctly.

// File: rtl/plg_pkg.sv
package plg_pkg;

    localparam int OP_W  = 4;
    localparam int MAX_W = 8;

    typedef enum logic [OP_W-1:0] {
        OP_ADD, OP_SUB, OP_RSUB, OP_NOTL,
        OP_AND, OP_NAND, OP_OR, OP_NOR,
        OP_XOR, OP_ANDN, OP_MULLO, OP_MULHI,
        OP_SHIFT, OP_RSV13, OP_RSV14, OP_RSV15
    } op_e;

    typedef enum logic [1:0] {
        SH_LSL, SH_LSR, SH_ROL, SH_ROR
    } sh_e;

    typedef enum logic {
        LD_FILL,
        LD_OPER
    } ld_state_e;

    // Reference result for one table entry; w is the operand width and
    // aw the width of the shift-amount field.
    function automatic logic [MAX_W-1:0] slot_eval(
        input logic [OP_W-1:0]  op,
        input logic [MAX_W-1:0] l,
        input logic [MAX_W-1:0] r,
        input int               w,
        input int               aw
    );
        int  mask;
        int  li;
        int  ri;
        int  res;
        int  amt;
        int  rot;
        sh_e kind;
        mask = (1 << w) - 1;
        li   = int'(l) & mask;
        ri   = int'(r) & mask;
        res  = 0;
        kind = sh_e'(2'((ri >> (w - 2)) & 3));
        amt  = ri & ((1 << aw) - 1);
        rot  = amt % w;
        case (op_e'(op))
            OP_ADD:   res = li + ri;
            OP_SUB:   res = li - ri;
            OP_RSUB:  res = ri - li;
            OP_NOTL:  res = ~li;
            OP_AND:   res = li & ri;
            OP_NAND:  res = ~(li & ri);
            OP_OR:    res = li | ri;
            OP_NOR:   res = ~(li | ri);
            OP_XOR:   res = li ^ ri;
            OP_ANDN:  res = li & ~ri;
            OP_MULLO: res = li * ri;
            OP_MULHI: res = (li * ri) >> w;
            OP_SHIFT: begin
                case (kind)
                    SH_LSL:  res = (amt >= w) ? 0 : (li << amt);
                    SH_LSR:  res = (amt >= w) ? 0 : (li >> amt);
                    SH_ROL:  res = (li << rot) | (li >> (w - rot));
                    default: res = (li >> rot) | (li << (w - rot));
                endcase
            end
            default:  res = 0;
        endcase
        return MAX_W'(res & mask);
    endfunction

endpackage

// File: rtl/plg_loader.sv
module plg_loader
    import plg_pkg::*;
#(
    parameter int OPND_W = 4
) (
    input  logic                        clk,
    input  logic                        rst,
    output logic                        wr_en,
    output logic [OP_W+2*OPND_W-1:0]    wr_addr,
    output logic [OPND_W-1:0]           wr_data,
    output logic                        ready
);
    localparam int AW    = OP_W + 2 * OPND_W;
    localparam int AMT_W = $clog2(OPND_W);
    localparam logic [AW-1:0] LAST = '1;

    ld_state_e           state;
    logic [AW-1:0]       cnt;
    logic [OP_W-1:0]     f_op;
    logic [OPND_W-1:0]   f_l;
    logic [OPND_W-1:0]   f_r;
    logic [MAX_W-1:0]    word;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= LD_FILL;
            cnt   <= '0;
            ready <= 1'b0;
        end else if (state == LD_FILL) begin
            cnt <= cnt + 1'b1;
            if (cnt == LAST) begin
                state <= LD_OPER;
                ready <= 1'b1;
            end
        end
    end

    assign f_op = cnt[AW-1 -: OP_W];
    assign f_l  = cnt[2*OPND_W-1 -: OPND_W];
    assign f_r  = cnt[OPND_W-1:0];

    always_comb begin
        word = slot_eval(f_op, MAX_W'(f_l), MAX_W'(f_r), OPND_W, AMT_W);
    end

    assign wr_en   = (state == LD_FILL);
    assign wr_addr = cnt;
    assign wr_data = word[OPND_W-1:0];

endmodule

// File: rtl/plg_table.sv
module plg_table #(
    parameter int AW = 12,
    parameter int DW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wd,
    output logic [DW-1:0] q
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[addr] <= wd;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q <= mem[addr];
        end
    end

endmodule

// File: rtl/prog_lut_gate.sv
module prog_lut_gate
    import plg_pkg::*;
#(
    parameter int OPND_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [3:0]        op_sel,
    input  logic [OPND_W-1:0] opnd_l,
    input  logic [OPND_W-1:0] opnd_r,
    output logic [OPND_W-1:0] result,
    output logic              ready
);
    localparam int AW = OP_W + 2 * OPND_W;

    logic              ld_we;
    logic [AW-1:0]     ld_addr;
    logic [OPND_W-1:0] ld_data;
    logic [AW-1:0]     tbl_addr;
    logic [OPND_W-1:0] tbl_q;
    logic              rd_ok;

    plg_loader #(.OPND_W(OPND_W)) u_loader (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (ld_we),
        .wr_addr (ld_addr),
        .wr_data (ld_data),
        .ready   (ready)
    );

    // Mode switch: the loader owns the address while it fills.
    assign tbl_addr = ld_we ? ld_addr : {op_sel, opnd_l, opnd_r};

    plg_table #(.AW(AW), .DW(OPND_W)) u_table (
        .clk  (clk),
        .rst  (rst),
        .we   (ld_we),
        .addr (tbl_addr),
        .wd   (ld_data),
        .q    (tbl_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ok <= 1'b0;
        end else begin
            rd_ok <= ready;
        end
    end

    assign result = rd_ok ? tbl_q : '0;

endmodule

// File: rtl/plg_chk.sv
module plg_chk #(
    parameter int OPND_W = 4
) (
    input logic              clk,
    input logic              rst,
    input logic [3:0]        op_sel,
    input logic [OPND_W-1:0] opnd_l,
    input logic [OPND_W-1:0] opnd_r,
    input logic [OPND_W-1:0] result,
    input logic              ready
);
    localparam int AW = 4 + 2 * OPND_W;
    localparam logic [AW:0] FILL_LEN = (AW+1)'(1) << AW;

    logic [AW:0]       fill_cyc;
    logic [OPND_W-1:0] sum_exp;

    always_ff @(posedge clk) begin
        if (rst) begin
            fill_cyc <= '0;
        end else if (!ready) begin
            fill_cyc <= fill_cyc + 1'b1;
        end
    end

    assign sum_exp = opnd_l + opnd_r;

    // R7
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (!ready && result == '0));

    // R7
    fill_length_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ready) |-> fill_cyc == FILL_LEN);

    // R8
    early_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !ready |=> result == '0);

    // R9
    ready_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        ready |=> ready);

    // R6
    empty_slot_chk: assert property (@(posedge clk) disable iff (rst)
        (ready && op_sel >= 4'd13) |=> result == '0);

    // R2
    add_slot_chk: assert property (@(posedge clk) disable iff (rst)
        (ready && op_sel == 4'd0) |=> result == $past(sum_exp));

endmodule

bind prog_lut_gate plg_chk #(.OPND_W(OPND_W)) u_plg_chk (
    .clk    (clk),
    .rst    (rst),
    .op_sel (op_sel),
    .opnd_l (opnd_l),
    .opnd_r (opnd_r),
    .result (result),
    .ready  (ready)
);

// File: tb/tb_prog_lut_gate.sv
`timescale 1ns/1ps
module tb_prog_lut_gate;
    localparam int W = 6;
    localparam int N = 1 << (4 + 2 * W);

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [3:0]   op_sel = '0;
    logic [W-1:0] opnd_l = '0;
    logic [W-1:0] opnd_r = '0;
    logic [W-1:0] result;
    logic         ready;

    int compared   = 0;
    int mismatched = 0;

    always #5 clk = ~clk;

    prog_lut_gate #(.OPND_W(W)) dut (
        .clk(clk), .rst(rst), .op_sel(op_sel), .opnd_l(opnd_l),
        .opnd_r(opnd_r), .result(result), .ready(ready)
    );

    function automatic logic [W-1:0] model(input logic [3:0] op,
                                           input logic [W-1:0] l,
                                           input logic [W-1:0] r);
        logic [2*W-1:0] prod;
        logic [2*W-1:0] dbl;
        logic [2:0]     amt;
        int             a;
        prod = {{W{1'b0}}, l} * {{W{1'b0}}, r};
        amt  = r[2:0];
        a    = int'(amt) % W;
        case (op)
            4'd0:  return l + r;
            4'd1:  return l - r;
            4'd2:  return r - l;
            4'd3:  return ~l;
            4'd4:  return l & r;
            4'd5:  return ~(l & r);
            4'd6:  return l | r;
            4'd7:  return ~(l | r);
            4'd8:  return l ^ r;
            4'd9:  return l & ~r;
            4'd10: return prod[W-1:0];
            4'd11: return prod[2*W-1:W];
            4'd12: begin
                case (r[5:4])
                    2'b00: return (amt >= 3'd6) ? '0 : l << amt;
                    2'b01: return (amt >= 3'd6) ? '0 : l >> amt;
                    2'b10: begin dbl = {l, l} << a; return dbl[2*W-1:W]; end
                    default: begin dbl = {l, l} >> a; return dbl[W-1:0]; end
                endcase
            end
            default: return '0;
        endcase
    endfunction

    function automatic string tag_of(input logic [3:0] op);
        if (op <= 4'd2)  return "R2";
        if (op <= 4'd9)  return "R3";
        if (op <= 4'd11) return "R4";
        if (op == 4'd12) return "R5";
        return "R6";
    endfunction

    task automatic check(input string tag, input logic [W-1:0] act,
                         input logic [W-1:0] exp, input string what);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic lookup(input logic [3:0] op, input logic [W-1:0] l,
                          input logic [W-1:0] r);
        @(negedge clk);
        op_sel = op; opnd_l = l; opnd_r = r;
        @(negedge clk);
        check(tag_of(op), result, model(op, l, r),
              $sformatf("op %0d L %0d R %0d", op, l, r));
    endtask

    task automatic wait_fill(input string tag);
        int cyc = 0;
        while (!ready && cyc < N + 16) begin
            op_sel = 4'($urandom); opnd_l = 6'($urandom); opnd_r = 6'($urandom);
            @(negedge clk);
            cyc++;
            if (cyc % 8192 == 0 || ready)
                check("R8", result, '0, "lookup during fill");
        end
        check(tag, W'(cyc == N), W'(1), $sformatf("fill took %0d cycles", cyc));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        void'($urandom(32'd1729));
        repeat (3) @(negedge clk);
        check("R7", W'(ready), '0, "ready in reset");
        check("R7", result, '0, "result in reset");
        rst = 1'b0;
        wait_fill("R7");

        // R1: address order and one-cycle latency
        lookup(4'd1, 6'd10, 6'd3);
        check("R1", result, 6'd7, "latency of sub 10-3");
        lookup(4'd2, 6'd10, 6'd3);
        check("R1", result, 6'd57, "operand order of reverse sub");

        lookup(4'd0, 6'd63, 6'd1);
        lookup(4'd1, 6'd0, 6'd1);
        lookup(4'd3, 6'd0, 6'd0);
        lookup(4'd9, 6'h3F, 6'h0F);
        lookup(4'd10, 6'd63, 6'd63);
        lookup(4'd11, 6'd63, 6'd63);
        check("R4", result, 6'd62, "high product 63*63");
        // R5 corners: amounts 6 and 7, rotate wrap
        lookup(4'd12, 6'b101101, {2'b00, 4'd6});
        check("R5", result, '0, "lsl by 6");
        lookup(4'd12, 6'b101101, {2'b01, 4'd7});
        lookup(4'd12, 6'b101101, {2'b10, 4'd7});
        check("R5", result, 6'b011011, "rol by 7");
        lookup(4'd12, 6'b101101, {2'b11, 4'd6});
        check("R5", result, 6'b101101, "ror by 6");
        lookup(4'd12, 6'b101101, {2'b11, 4'd1});
        lookup(4'd12, 6'b000111, {2'b00, 4'd2});
        for (int op = 13; op < 16; op++) lookup(4'(op), 6'd63, 6'd63);

        for (int i = 0; i < 3000; i++)
            lookup(4'($urandom), 6'($urandom), 6'($urandom));
        check("R9", W'(ready), W'(1), "ready after traffic");

        // R10: reset in operating mode reloads
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check("R10", W'(ready), '0, "ready after mid-run reset");
        rst = 1'b0;
        wait_fill("R10");
        lookup(4'd11, 6'd40, 6'd50);
        lookup(4'd8, 6'd21, 6'd42);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule